// File: doc/BRIEF.md
# Oversampled Asynchronous Frame Receiver with Address Filter

This block takes a serial line and turns 10-bit or 11-bit asynchronous frames into parallel bytes. Each frame is a low start bit, then eight data bits with the least significant bit first, then one optional extra bit, then a high stop bit. The line is watched on a sampling strobe that runs at sixteen times the bit rate. A falling edge seen while idle re-aligns the bit-phase counter, so bit timing follows the incoming frame. Each bit is then resolved by a two-of-three majority vote taken near the middle of the bit.

A start bit that does not hold low at mid-bit is treated as noise and discarded. A completed frame reaches the output holding register only when two things are true: the previous byte has been taken, which means the ready flag is clear, and the address filter either is off or sees a 1 in the last significant bit. Otherwise the frame is dropped without any sign. A new frame may start arriving while the previous byte is still unread.

Top module: `mpx_rx`

## Requirements
- R1: After reset, rx_rdy_o, rx_data_o and rx_bit9_o are all 0.
- R2: A falling edge whose majority-voted first bit is 1 (a line that goes low and returns high before the mid-bit samples) is abandoned: nothing is delivered, and the next proper frame is received correctly.
- R3: Each bit takes the majority of three samples taken on consecutive strobes near mid-bit. A single corrupted sample inside a bit does not change the received value.
- R4: With frame_sel_i = 0 (10-bit frame), the eight data bits, LSB first, appear on rx_data_o, the stop bit appears on rx_bit9_o, and rx_rdy_o goes to 1.
- R5: With frame_sel_i = 1 (11-bit frame), the bit after the eight data bits appears on rx_bit9_o. The value of the stop bit has no effect on delivery.
- R6: A frame that completes while rx_rdy_o is 1 is discarded. rx_data_o and rx_bit9_o keep the earlier byte.
- R7: With addr_filt_i = 1, a frame whose last significant bit is 0 is discarded. This bit is the ninth bit in 11-bit mode and the stop bit in 10-bit mode. A frame whose last significant bit is 1 is delivered.
- R8: While rx_en_i = 0, no frame is received and rx_rdy_o does not rise.
- R9: A frame that begins while rx_rdy_o is 1 is delivered if rx_rdy_clr_i clears the flag before the frame completes.
- R10: rx_rdy_o stays 1 until a cycle with rx_rdy_clr_i = 1, and it reads 0 in the cycle after that one. rx_data_o and rx_bit9_o do not change while rx_rdy_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| tick16_i | input | 1 | One-cycle strobe at OVS times the bit rate |
| rx_en_i | input | 1 | Receive enable. When 0, reception is aborted and new frames are ignored |
| addr_filt_i | input | 1 | Address filter. When 1, a frame whose last significant bit is 0 is dropped |
| frame_sel_i | input | 1 | Frame length: 0 = 10-bit frame, 1 = 11-bit frame |
| rx_rdy_clr_i | input | 1 | Clears rx_rdy_o |
| rx_data_o | output | DATA_W | Received data byte |
| rx_bit9_o | output | 1 | Stop bit (10-bit mode) or ninth bit (11-bit mode) |
| rx_rdy_o | output | 1 | Byte-ready flag |

## Verification
The bench builds the block with DATA_W = 8 and OVS = 16, with a sampling strobe every third clock, so one bit lasts 48 clocks. With these values, the three vote samples fall on strobes 7, 8 and 9 of each bit. A three-clock glitch therefore corrupts at most one sample, and a false start that lasts four strobes lies wholly before the vote window. A scoreboard predicts which frames must be dropped, either because the ready flag is still held or because the filter rejects them. It also covers the case where the flag is cleared in the middle of a frame.

// File: rtl/mpx_rx_pkg.sv
package mpx_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BITS = 2'd1,
    ST_TAIL = 2'd2
  } rx_st_e;
endpackage

// File: rtl/mpx_rx_sync.sv
module mpx_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mpx_rx_vote.sv
module mpx_rx_vote #(
  parameter int OVS = 16,
  localparam int CW = $clog2(OVS),
  localparam int S0 = OVS/2 - 1,
  localparam int S1 = OVS/2,
  localparam int S2 = OVS/2 + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          rxs_i,
  output logic          strobe_o,
  output logic          vote_o
);
  logic s_a, s_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_a <= 1'b1;
      s_b <= 1'b1;
    end else if (tick_i) begin
      if (cnt_i == CW'(S0)) s_a <= rxs_i;
      if (cnt_i == CW'(S1)) s_b <= rxs_i;
    end
  end

  assign strobe_o = tick_i && (cnt_i == CW'(S2));
  assign vote_o   = (s_a & s_b) | (s_a & rxs_i) | (s_b & rxs_i);
endmodule

// File: rtl/mpx_rx_frame.sv
module mpx_rx_frame
  import mpx_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  localparam int CW = $clog2(OVS),
  localparam int SW = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              rxs_i,
  input  logic              en_i,
  input  logic              filt_i,
  input  logic              sel_i,
  input  logic              clr_i,
  input  logic              strobe_i,
  input  logic              vote_i,
  output logic [CW-1:0]     cnt_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              rdy_o
);
  rx_st_e        st;
  logic [SW-1:0] sh;
  logic          prev;
  logic [CW-1:0] cnt_nxt;
  logic          last_bit;
  logic          accept;

  assign cnt_nxt  = (cnt_o == CW'(OVS-1)) ? '0 : cnt_o + 1'b1;
  assign last_bit = !sh[1];
  assign accept   = !rdy_o && (!filt_i || vote_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt_o  <= '0;
      sh     <= '1;
      prev   <= 1'b1;
      rdy_o  <= 1'b0;
      data_o <= '0;
      bit9_o <= 1'b0;
    end else begin
      if (clr_i)  rdy_o <= 1'b0;
      if (tick_i) prev  <= rxs_i;
      if (!en_i) begin
        st <= ST_IDLE;
      end else begin
        case (st)
          ST_IDLE: begin
            if (tick_i && prev && !rxs_i) begin
              st    <= ST_BITS;
              cnt_o <= '0;
              sh    <= '1;
            end
          end
          ST_BITS: begin
            if (tick_i) cnt_o <= cnt_nxt;
            if (strobe_i) begin
              if (&sh && vote_i) begin
                st <= ST_IDLE;
              end else begin
                sh <= {vote_i, sh[SW-1:1]};
                if (last_bit) begin
                  if (accept) begin
                    data_o <= sh[SW-1:2];
                    bit9_o <= vote_i;
                    rdy_o  <= 1'b1;
                  end
                  st <= sel_i ? ST_TAIL : ST_IDLE;
                end
              end
            end
          end
          ST_TAIL: begin
            if (tick_i)   cnt_o <= cnt_nxt;
            if (strobe_i) st    <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpx_rx.sv
module mpx_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(OVS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd_i,
  input  logic              tick16_i,
  input  logic              rx_en_i,
  input  logic              addr_filt_i,
  input  logic              frame_sel_i,
  input  logic              rx_rdy_clr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_bit9_o,
  output logic              rx_rdy_o
);
  logic          rxs;
  logic [CW-1:0] cnt;
  logic          strobe;
  logic          vote;

  mpx_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (rxd_i),
    .q_o (rxs)
  );

  mpx_rx_vote #(.OVS(OVS)) u_vote (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick16_i),
    .cnt_i    (cnt),
    .rxs_i    (rxs),
    .strobe_o (strobe),
    .vote_o   (vote)
  );

  mpx_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick16_i),
    .rxs_i    (rxs),
    .en_i     (rx_en_i),
    .filt_i   (addr_filt_i),
    .sel_i    (frame_sel_i),
    .clr_i    (rx_rdy_clr_i),
    .strobe_i (strobe),
    .vote_i   (vote),
    .cnt_o    (cnt),
    .data_o   (rx_data_o),
    .bit9_o   (rx_bit9_o),
    .rdy_o    (rx_rdy_o)
  );
endmodule

// File: rtl/mpx_rx_chk.sv
module mpx_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick16_i,
  input logic              rx_en_i,
  input logic              addr_filt_i,
  input logic              rx_rdy_clr_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_bit9_o,
  input logic              rx_rdy_o
);
  p_rdy_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_rdy_o && !rx_rdy_clr_i) |=> rx_rdy_o);

  p_clr_drops_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_rdy_o && rx_rdy_clr_i) |=> !rx_rdy_o);

  p_no_overwrite_r6: assert property (@(posedge clk) disable iff (rst)
    rx_rdy_o |=> ($stable(rx_data_o) && $stable(rx_bit9_o)));

  p_filter_bit_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_rdy_o) && $past(addr_filt_i)) |-> rx_bit9_o);

  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !rx_en_i |=> !$rose(rx_rdy_o));

  p_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_rdy_o) |-> $past(tick16_i));
endmodule

bind mpx_rx mpx_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick16_i     (tick16_i),
  .rx_en_i      (rx_en_i),
  .addr_filt_i  (addr_filt_i),
  .rx_rdy_clr_i (rx_rdy_clr_i),
  .rx_data_o    (rx_data_o),
  .rx_bit9_o    (rx_bit9_o),
  .rx_rdy_o     (rx_rdy_o)
);

// File: tb/sim_mpx_rx.sv
module sim_mpx_rx;
  localparam int CLK_NS  = 10;
  localparam int TDIV    = 3;
  localparam int OVS     = 16;
  localparam int BIT_CLK = TDIV * OVS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       tick = 1'b0;
  logic       en = 1'b0;
  logic       filt = 1'b0;
  logic       sel = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] dout;
  logic       b9;
  logic       rdy;

  int n_chk = 0;
  int n_bad = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic       m_rdy  = 1'b0;
  logic [7:0] m_data = 8'h00;
  logic       m_b9   = 1'b0;
  logic       rdy_q  = 1'b0;

  mpx_rx #(.DATA_W(8), .OVS(OVS), .SYNC_STAGES(2)) u0 (
    .clk          (clk),
    .rst          (rst),
    .rxd_i        (rxd),
    .tick16_i     (tick),
    .rx_en_i      (en),
    .addr_filt_i  (filt),
    .frame_sel_i  (sel),
    .rx_rdy_clr_i (clr),
    .rx_data_o    (dout),
    .rx_bit9_o    (b9),
    .rx_rdy_o     (rdy)
  );

  always #(CLK_NS/2) clk = ~clk;

  initial begin
    forever begin
      for (int i = 0; i < TDIV; i++) begin
        @(negedge clk);
        tick = (i == 0);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!rst && rdy && !rdy_q) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected delivery", {23'd0, b9, dout}, 0);
      end else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({b9, dout} == e, t, {23'd0, b9, dout}, {23'd0, e});
      end
    end
    rdy_q = rdy;
  end

  task automatic drive_bit(input logic v, input int gl);
    rxd = v;
    for (int c = 0; c < BIT_CLK; c++) begin
      @(negedge clk);
      if (gl != 0) rxd = (c >= 21 && c < 24) ? ~v : v;
    end
  endtask

  task automatic clear_rdy();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_rdy = 1'b0;
  endtask

  task automatic frame(input logic [7:0] d, input logic nb, input logic stopv,
                       input int clr_at, input int gl_bit, input string tag);
    logic [10:0] bits;
    int          nbits;
    logic        fin;
    bit          pre_rdy;
    nbits = sel ? 11 : 10;
    bits  = sel ? {stopv, nb, d, 1'b0} : {1'b0, stopv, d, 1'b0};
    fin   = sel ? nb : stopv;
    pre_rdy = (clr_at >= 0) ? 1'b0 : m_rdy;
    if (en && !pre_rdy && (!filt || fin)) begin
      exp_q.push_back({fin, d});
      tag_q.push_back(tag);
    end
    for (int k = 0; k < nbits; k++) begin
      if (k == clr_at) begin
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        rxd = bits[k];
        for (int c = 1; c < BIT_CLK; c++) @(negedge clk);
      end else begin
        drive_bit(bits[k], (k == gl_bit) ? 1 : 0);
      end
    end
    if (clr_at >= 0) m_rdy = 1'b0;
    if (en && !pre_rdy && (!filt || fin)) begin
      m_rdy  = 1'b1;
      m_data = d;
      m_b9   = fin;
    end
    drive_bit(1'b1, 0);
    drive_bit(1'b1, 0);
    check(rdy == m_rdy, {tag, " flag"}, rdy, m_rdy);
    check(dout == m_data && b9 == m_b9, {tag, " buffer"}, {b9, dout}, {m_b9, m_data});
    check(exp_q.size() == 0, {tag, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_NS * 190000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    check(rdy == 1'b0 && dout == 8'h00 && b9 == 1'b0, "R1 reset state",
          {rdy, b9, dout}, 0);
    rst = 1'b0;
    en  = 1'b1;
    repeat (BIT_CLK) @(negedge clk);

    // R4: 10-bit frames, stop bit lands in rx_bit9_o
    frame(8'hA5, 1'b0, 1'b1, -1, -1, "R4 ten-bit A5");
    clear_rdy();
    check(rdy == 1'b0, "R10 clear next cycle", rdy, 0);
    frame(8'h01, 1'b0, 1'b1, -1, -1, "R4 ten-bit 01");
    clear_rdy();

    // R3: one corrupted sample inside data bit 3 and data bit 6
    frame(8'h3C, 1'b0, 1'b1, -1, 4, "R3 glitch bit3");
    clear_rdy();
    frame(8'hC9, 1'b0, 1'b1, -1, 7, "R3 glitch bit6");
    clear_rdy();

    // R2: short low pulse, then a real frame
    rxd = 1'b0;
    repeat (4 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    check(rdy == 1'b0, "R2 false start ignored", rdy, 0);
    frame(8'h81, 1'b0, 1'b1, -1, -1, "R2 frame after false start");
    clear_rdy();

    // R5: 11-bit frames, ninth bit to rx_bit9_o, stop value ignored
    sel = 1'b1;
    frame(8'h5A, 1'b1, 1'b0, -1, -1, "R5 nine=1 stop=0");
    clear_rdy();
    frame(8'h0F, 1'b0, 1'b1, -1, -1, "R5 nine=0 stop=1");

    // R6: flag still held, next frame dropped; R10 flag held
    frame(8'hC3, 1'b1, 1'b1, -1, -1, "R6 dropped while held");
    check(rdy == 1'b1, "R10 flag held without clear", rdy, 1);
    clear_rdy();
    check(rdy == 1'b0, "R10 flag cleared", rdy, 0);

    // R7: address filter
    filt = 1'b1;
    frame(8'h11, 1'b0, 1'b1, -1, -1, "R7 nine=0 filtered");
    frame(8'h22, 1'b1, 1'b1, -1, -1, "R7 nine=1 passes");
    clear_rdy();
    sel = 1'b0;
    frame(8'h33, 1'b0, 1'b0, -1, -1, "R7 ten-bit stop=0 filtered");
    frame(8'h34, 1'b0, 1'b1, -1, -1, "R7 ten-bit stop=1 passes");
    clear_rdy();
    filt = 1'b0;

    // R8: receiver disabled
    en = 1'b0;
    frame(8'h44, 1'b0, 1'b1, -1, -1, "R8 disabled");
    en = 1'b1;
    repeat (BIT_CLK) @(negedge clk);
    frame(8'h45, 1'b0, 1'b1, -1, -1, "R8 re-enabled");

    // R9: next frame starts while unread, flag cleared mid-frame
    sel = 1'b1;
    frame(8'h77, 1'b1, 1'b1, 4, -1, "R9 overlap delivered");
    clear_rdy();

    finish_run();
  end
endmodule